// File: doc/BRIEF.md
# Reduced-Pin Double-Data-Rate Ethernet Line Codec

This block sits between a byte-wide MAC-side beat stream and a reduced Ethernet physical link that has four data wires and one control wire in each direction. On the transmit side it takes beats of one data byte, an enable flag and an error flag. It drives them onto the nibble-wide line, timed to the transmit clock that the MAC side supplies. On the receive side it samples the nibble-wide line on the receive clock that the PHY side supplies, and it rebuilds the byte together with its valid and error flags. Carrier-sense and collision wires are not part of the link.

The speed-select input `gig_mode` picks how the line is used. At 1000 Mbit/s both clock edges carry data, so one byte goes across per clock. At 10/100 Mbit/s only the rising edge carries data, so one byte takes two clocks. The control wire has the same encoding in both modes: it holds the enable flag while the clock is high and the XOR of enable and error while the clock is low. The receiver gets the error flag back by XORing the two halves of the control wire. The double-data-rate pads are modelled with separate rising-edge and falling-edge registers. The skew between clock and data is left to the board or to pad logic outside this block. `gig_mode` may only change while both directions are idle.

The transmit input is a valid/ready stream. A beat transfers on a rising edge of `tx_clk` where both `tx_valid` and `tx_ready` are high. While `tx_valid` is high and `tx_ready` is low, the source must hold the beat unchanged. At 1000 Mbit/s `tx_ready` never drops. At 10/100 Mbit/s it drops for the clock that carries the second nibble. The receive output cannot apply back-pressure, because the line has none. Each clock in which `rx_valid` is high delivers one beat, and the consumer must take it in that clock.

Top module: `rgmii_ddr_codec`

## Requirements
- R1: With `gig_mode`=1, `tx_ready` stays high. Each accepted beat occupies one `tx_clk` period, with `tx_data[3:0]` on `txd` while `tx_clk` is high and `tx_data[7:4]` while it is low.
- R2: In both modes, `tx_ctl` carries `tx_en` while `tx_clk` is high and `tx_en` XOR `tx_er` while `tx_clk` is low.
- R3: With `gig_mode`=0, an accepted byte occupies two `tx_clk` periods. `txd` holds `tx_data[3:0]` for the whole first period and `tx_data[7:4]` for the whole second period. `tx_ready` is low in the period after an acceptance and high again in the period after that.
- R4: In any `tx_clk` period that carries no beat, `txd` and `tx_ctl` are zero in both halves.
- R5: With `gig_mode`=1, each receive period gives the byte {falling-half nibble, rising-half nibble}, `rx_dv` equal to the rising-half control value, and `rx_er` equal to the XOR of the two control halves. `rx_valid` is high when either flag is set.
- R6: With `gig_mode`=0, the receiver pairs rising-edge nibbles with the low nibble first. A period in which both control halves are zero is idle and restarts the pairing. A byte is delivered on its second nibble, so `rx_valid` is never high in two periods in a row.
- R7: While `rx_valid` is low, `rx_dv`, `rx_er` and `rx_data` are all zero.
- R8: An accepted beat with both `tx_en` and `tx_er` clear is sent as idle, and the far end never delivers it.
- R9: Right after reset, `txd`, `tx_ctl` and `rx_valid` are zero and `tx_ready` is high.
- R10: With the line looped back, every beat with `tx_en` or `tx_er` set comes out in order, with identical data, enable and error, in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock, supplied by the MAC side |
| tx_rst_n | input | 1 | Active-low asynchronous reset, transmit side |
| rx_clk | input | 1 | Receive clock, supplied by the PHY side |
| rx_rst_n | input | 1 | Active-low asynchronous reset, receive side |
| gig_mode | input | 1 | 1: both edges carry data (1000 Mbit/s); 0: rising edge only |
| tx_valid | input | 1 | Transmit beat offered |
| tx_ready | output | 1 | Transmit beat accepted on this edge if valid |
| tx_en | input | 1 | Beat enable flag |
| tx_er | input | 1 | Beat error flag |
| tx_data | input | 8 | Beat data byte |
| txd | output | 4 | Line data, transmit |
| tx_ctl | output | 1 | Line control, transmit |
| rxd | input | 4 | Line data, receive |
| rx_ctl | input | 1 | Line control, receive |
| rx_valid | output | 1 | Decoded beat present this period |
| rx_dv | output | 1 | Decoded enable (data valid) flag |
| rx_er | output | 1 | Decoded error flag |
| rx_data | output | 8 | Decoded data byte |

## Verification
The assertions watch the handshake rules and the receive-side output contract on every clock. They check that `tx_ready` holds at 1000 Mbit/s and drops after each acceptance at 10/100 Mbit/s. They also check that the receive flags are zero whenever no beat is delivered, and that single-edge mode never delivers two bytes in consecutive periods. The exact nibble and control levels in each half period, and the pairing order at the slower speed, can only be shown by the bench's line probes. The same holds for idle beats being dropped and for faithful round trips of every flag combination. The bench shows these by probing `txd`/`tx_ctl` in mid-half and by checking the loopback stream against its scoreboard.

// File: rtl/rgmii_pkg.sv
package rgmii_pkg;

  // Control wire value for the low clock half: enable XOR error.
  function automatic logic ctl_low_half(input logic en, input logic er);
    return en ^ er;
  endfunction

  // Error flag recovered from the two halves of the control wire.
  function automatic logic err_from_halves(input logic hi_half, input logic lo_half);
    return hi_half ^ lo_half;
  endfunction

  // A period is idle when both control halves are low.
  function automatic logic halves_idle(input logic hi_half, input logic lo_half);
    return !hi_half && !lo_half;
  endfunction

endpackage

// File: rtl/rgmii_ddr_out.sv
// Behavioural double-data-rate output: the rising-edge register drives the pin
// while the clock is high, and the falling-edge register drives it while low.
module rgmii_ddr_out #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_hi,
  input  logic [W-1:0] d_lo,
  output logic [W-1:0] q
);
  logic [W-1:0] hi_q;
  logic [W-1:0] lo_stage;
  logic [W-1:0] lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q     <= '0;
      lo_stage <= '0;
    end else begin
      hi_q     <= d_hi;
      lo_stage <= d_lo;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= '0;
    else        lo_q <= lo_stage;
  end

  assign q = clk ? hi_q : lo_q;
endmodule

// File: rtl/rgmii_ddr_in.sv
// Behavioural double-data-rate input: one register per clock edge.
module rgmii_ddr_in #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_hi,
  output logic [W-1:0] q_lo
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_hi <= '0;
    else        q_hi <= d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q_lo <= '0;
    else        q_lo <= d;
  end
endmodule

// File: rtl/rgmii_tx_enc.sv
// Turns byte beats into {ctl, nibble} values for the high and low clock halves.
module rgmii_tx_enc
  import rgmii_pkg::*;
#(
  parameter int NW = 4,
  localparam int DW = 2 * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gig,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_en,
  input  logic          in_er,
  input  logic [DW-1:0] in_data,
  output logic [NW:0]   half_hi,
  output logic [NW:0]   half_lo
);
  logic          second;     // 10/100: second nibble of a byte goes out now
  logic [NW-1:0] held_hi;
  logic          held_en;
  logic          held_er;
  logic          fire;

  assign in_ready = gig || !second;
  assign fire     = in_valid && in_ready;

  always_comb begin
    half_hi = '0;
    half_lo = '0;
    if (second) begin
      half_hi = {held_en, held_hi};
      half_lo = {ctl_low_half(held_en, held_er), held_hi};
    end else if (fire) begin
      half_hi = {in_en, in_data[NW-1:0]};
      if (gig) half_lo = {ctl_low_half(in_en, in_er), in_data[DW-1:NW]};
      else     half_lo = {ctl_low_half(in_en, in_er), in_data[NW-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second  <= 1'b0;
      held_hi <= '0;
      held_en <= 1'b0;
      held_er <= 1'b0;
    end else begin
      second <= 1'b0;
      if (!gig && !second && fire) begin
        second  <= 1'b1;
        held_hi <= in_data[DW-1:NW];
        held_en <= in_en;
        held_er <= in_er;
      end
    end
  end
endmodule

// File: rtl/rgmii_rx_dec.sv
// Rebuilds byte beats from the sampled high and low halves of the line.
module rgmii_rx_dec
  import rgmii_pkg::*;
#(
  parameter int NW = 4,
  localparam int DW = 2 * NW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gig,
  input  logic [NW-1:0] hi_d,
  input  logic          hi_c,
  input  logic [NW-1:0] lo_d,
  input  logic          lo_c,
  output logic          out_valid,
  output logic          out_dv,
  output logic          out_er,
  output logic [DW-1:0] out_data
);
  logic          have_low;   // 10/100: low nibble captured, waiting for high
  logic [NW-1:0] low_nib;
  logic          idle;

  assign idle = halves_idle(hi_c, lo_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_low  <= 1'b0;
      low_nib   <= '0;
      out_valid <= 1'b0;
      out_dv    <= 1'b0;
      out_er    <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_dv    <= 1'b0;
      out_er    <= 1'b0;
      out_data  <= '0;
      if (gig) begin
        have_low <= 1'b0;
        if (!idle) begin
          out_valid <= 1'b1;
          out_dv    <= hi_c;
          out_er    <= err_from_halves(hi_c, lo_c);
          out_data  <= {lo_d, hi_d};
        end
      end else if (idle) begin
        have_low <= 1'b0;
      end else if (!have_low) begin
        have_low <= 1'b1;
        low_nib  <= hi_d;
      end else begin
        have_low  <= 1'b0;
        out_valid <= 1'b1;
        out_dv    <= hi_c;
        out_er    <= err_from_halves(hi_c, lo_c);
        out_data  <= {hi_d, low_nib};
      end
    end
  end
endmodule

// File: rtl/rgmii_ddr_codec.sv
module rgmii_ddr_codec #(
  parameter int NW = 4,
  localparam int DW = 2 * NW
) (
  input  logic          tx_clk,
  input  logic          tx_rst_n,
  input  logic          rx_clk,
  input  logic          rx_rst_n,
  input  logic          gig_mode,
  input  logic          tx_valid,
  output logic          tx_ready,
  input  logic          tx_en,
  input  logic          tx_er,
  input  logic [DW-1:0] tx_data,
  output logic [NW-1:0] txd,
  output logic          tx_ctl,
  input  logic [NW-1:0] rxd,
  input  logic          rx_ctl,
  output logic          rx_valid,
  output logic          rx_dv,
  output logic          rx_er,
  output logic [DW-1:0] rx_data
);
  logic [NW:0] enc_hi;
  logic [NW:0] enc_lo;
  logic [NW:0] line_tx;
  logic [NW:0] samp_hi;
  logic [NW:0] samp_lo;

  rgmii_tx_enc #(.NW(NW)) tx_enc_i (
    .clk      (tx_clk),
    .rst_n    (tx_rst_n),
    .gig      (gig_mode),
    .in_valid (tx_valid),
    .in_ready (tx_ready),
    .in_en    (tx_en),
    .in_er    (tx_er),
    .in_data  (tx_data),
    .half_hi  (enc_hi),
    .half_lo  (enc_lo)
  );

  rgmii_ddr_out #(.W(NW + 1)) ddr_out_i (
    .clk   (tx_clk),
    .rst_n (tx_rst_n),
    .d_hi  (enc_hi),
    .d_lo  (enc_lo),
    .q     (line_tx)
  );

  assign tx_ctl = line_tx[NW];
  assign txd    = line_tx[NW-1:0];

  rgmii_ddr_in #(.W(NW + 1)) ddr_in_i (
    .clk   (rx_clk),
    .rst_n (rx_rst_n),
    .d     ({rx_ctl, rxd}),
    .q_hi  (samp_hi),
    .q_lo  (samp_lo)
  );

  rgmii_rx_dec #(.NW(NW)) rx_dec_i (
    .clk       (rx_clk),
    .rst_n     (rx_rst_n),
    .gig       (gig_mode),
    .hi_d      (samp_hi[NW-1:0]),
    .hi_c      (samp_hi[NW]),
    .lo_d      (samp_lo[NW-1:0]),
    .lo_c      (samp_lo[NW]),
    .out_valid (rx_valid),
    .out_dv    (rx_dv),
    .out_er    (rx_er),
    .out_data  (rx_data)
  );
endmodule

// File: rtl/rgmii_codec_chk.sv
module rgmii_codec_chk #(
  parameter int DW = 8
) (
  input logic          tx_clk,
  input logic          tx_rst_n,
  input logic          rx_clk,
  input logic          rx_rst_n,
  input logic          gig_mode,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          rx_valid,
  input logic          rx_dv,
  input logic          rx_er,
  input logic [DW-1:0] rx_data
);
  // R1
  gig_ready_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    gig_mode |-> tx_ready);

  // R3
  slow_ready_drop_chk: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (!gig_mode && tx_valid && tx_ready) |=> !tx_ready);

  // R5
  rx_flag_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rx_valid |-> (rx_dv || rx_er));

  // R7
  rx_quiet_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    !rx_valid |-> (!rx_dv && !rx_er && rx_data == '0));

  // R6
  slow_rx_gap_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    (!gig_mode && rx_valid) |=> !rx_valid);
endmodule

bind rgmii_ddr_codec rgmii_codec_chk #(.DW(DW)) chk_i (
  .tx_clk   (tx_clk),
  .tx_rst_n (tx_rst_n),
  .rx_clk   (rx_clk),
  .rx_rst_n (rx_rst_n),
  .gig_mode (gig_mode),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_dv    (rx_dv),
  .rx_er    (rx_er),
  .rx_data  (rx_data)
);

// File: tb/rgmii_ddr_codec_tb_top.sv
module rgmii_ddr_codec_tb_top;
  logic       tx_clk = 1'b0;
  logic       rx_clk = 1'b0;
  logic       tx_rst_n = 1'b0;
  logic       rx_rst_n = 1'b0;
  logic       gig_mode = 1'b1;
  logic       tx_valid = 1'b0;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_ready;
  logic [3:0] txd;
  logic       tx_ctl;
  logic       rx_valid, rx_dv, rx_er;
  logic [7:0] rx_data;

  int  n_chk = 0;
  int  n_bad = 0;
  int  n_sent = 0;
  int  n_got = 0;
  bit  done = 0;
  logic [9:0] exp_q[$];

  // 50 MHz transmit clock; receive clock lags by a quarter period (loopback skew).
  initial forever #10 tx_clk = ~tx_clk;
  initial begin #5; forever #10 rx_clk = ~rx_clk; end

  rgmii_ddr_codec dut_i (
    .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .rx_clk(rx_clk), .rx_rst_n(rx_rst_n),
    .gig_mode(gig_mode), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_en(tx_en), .tx_er(tx_er), .tx_data(tx_data),
    .txd(txd), .tx_ctl(tx_ctl), .rxd(txd), .rx_ctl(tx_ctl),
    .rx_valid(rx_valid), .rx_dv(rx_dv), .rx_er(rx_er), .rx_data(rx_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: caller stands at a tx_clk falling edge.
  task automatic send(input logic en, input logic er, input logic [7:0] d);
    tx_valid = 1'b1; tx_en = en; tx_er = er; tx_data = d;
    while (!tx_ready) @(negedge tx_clk);
    if (en || er) begin
      exp_q.push_back({er, en, d});
      n_sent++;
    end
    @(negedge tx_clk);
    tx_valid = 1'b0; tx_en = 1'b0; tx_er = 1'b0; tx_data = '0;
  endtask

  // Probe line levels mid-half for one beat; caller at a falling edge, line idle.
  task automatic line_probe(input logic en, input logic er, input logic [7:0] d);
    tx_valid = 1'b1; tx_en = en; tx_er = er; tx_data = d;
    @(posedge tx_clk);
    if (en || er) begin
      exp_q.push_back({er, en, d});
      n_sent++;
    end
    #1 tx_valid = 1'b0; tx_en = 1'b0; tx_er = 1'b0; tx_data = '0;
    #4;
    check(tx_ctl == en, "R2 ctl high half", tx_ctl, en);
    check(txd == d[3:0], gig_mode ? "R1 low nibble high half" : "R3 first period high half", txd, d[3:0]);
    #10;
    check(tx_ctl == (en ^ er), "R2 ctl low half", tx_ctl, en ^ er);
    if (gig_mode) check(txd == d[7:4], "R1 high nibble low half", txd, d[7:4]);
    else          check(txd == d[3:0], "R3 first period low half", txd, d[3:0]);
    if (!gig_mode) begin
      #10;
      check(tx_ctl == en, "R2 ctl high half second", tx_ctl, en);
      check(txd == d[7:4], "R3 second period high half", txd, d[7:4]);
      #10;
      check(tx_ctl == (en ^ er), "R2 ctl low half second", tx_ctl, en ^ er);
      check(txd == d[7:4], "R3 second period low half", txd, d[7:4]);
    end
    // next period carries no beat
    #10;
    check({tx_ctl, txd} == 5'h0, "R4 idle high half", {tx_ctl, txd}, 0);
    #10;
    check({tx_ctl, txd} == 5'h0, "R4 idle low half", {tx_ctl, txd}, 0);
    @(negedge tx_clk);
  endtask

  task automatic drain();
    repeat (12) @(negedge tx_clk);
    check(exp_q.size() == 0, "R10 all beats delivered", exp_q.size(), 0);
  endtask

  // Monitor / scoreboard
  always @(negedge rx_clk) begin
    if (rx_rst_n && rx_valid && !done) begin
      n_got++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected beat", {rx_er, rx_dv, rx_data}, 0);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        check({rx_er, rx_dv, rx_data} == e,
              gig_mode ? "R5 R10 gig loopback" : "R6 R10 slow loopback",
              {rx_er, rx_dv, rx_data}, e);
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      check(1'b0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge tx_clk);
    // R9 reset state
    check({tx_ctl, txd} == 5'h0, "R9 line zero in reset", {tx_ctl, txd}, 0);
    check(rx_valid == 1'b0, "R9 rx_valid low in reset", rx_valid, 0);
    tx_rst_n = 1'b1; rx_rst_n = 1'b1;
    @(negedge tx_clk);
    check(tx_ready == 1'b1, "R9 tx_ready after reset", tx_ready, 1);
    check(rx_valid == 1'b0, "R9 rx_valid after reset", rx_valid, 0);

    // ---- 1000 Mbit/s ----
    line_probe(1'b1, 1'b0, 8'hA5);
    line_probe(1'b1, 1'b1, 8'h3C);
    line_probe(1'b0, 1'b1, 8'h0F);
    for (int c = 0; c < 4; c++)
      foreach (exp_q[i]) ; // keep ordering simple
    for (int c = 0; c < 4; c++) begin
      send(c[0], c[1], 8'h00);
      send(c[0], c[1], 8'hFF);
      send(c[0], c[1], 8'h5A);
    end
    // R8 idle beats dropped
    send(1'b0, 1'b0, 8'hEE);
    send(1'b1, 1'b0, 8'h11);
    for (int i = 0; i < 300; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      send(r[8], r[9], r[7:0]);
    end
    drain();
    check(n_got == n_sent, "R8 delivered count gig", n_got, n_sent);

    // ---- 10/100 Mbit/s ----
    gig_mode = 1'b0;
    repeat (4) @(negedge tx_clk);
    line_probe(1'b1, 1'b0, 8'h3C);
    line_probe(1'b0, 1'b1, 8'hD2);
    line_probe(1'b1, 1'b1, 8'h81);
    // R3 ready drops for one period after acceptance
    send(1'b1, 1'b0, 8'h42);
    check(tx_ready == 1'b0, "R3 ready low after accept", tx_ready, 0);
    @(negedge tx_clk);
    check(tx_ready == 1'b1, "R3 ready back high", tx_ready, 1);
    for (int c = 0; c < 4; c++) begin
      send(c[0], c[1], 8'h0F);
      send(c[0], c[1], 8'hF0);
    end
    send(1'b0, 1'b0, 8'h77);
    for (int i = 0; i < 300; i++) begin
      logic [9:0] r;
      r = 10'($urandom);
      send(r[8], r[9], r[7:0]);
    end
    drain();
    check(n_got == n_sent, "R8 delivered count slow", n_got, n_sent);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule